// File: doc/BRIEF.md
# Stop-Mode Clock Sequencer

This block is the control part of a clock generator that takes the chip into and out of a low-power stop state. When the processor requests stop, the block shuts the clock tree down in a fixed order, one step per clock cycle. If the PLL is the current source, it first switches the tree to the oscillator. It then turns the PLL off, then the core clock, and last the remaining system clocks. At that point it raises a request that tells other units, such as the voltage regulator, to enter their own low-power states.

Two kinds of stop are supported. In full stop the oscillator is off. In pseudo stop the oscillator keeps running, and the real-time-interrupt and watchdog clocks can be kept alive through their own run enables. The block also handles the self-clock mode, in which the tree runs from the free-running PLL because the oscillator has been lost. Waking on an interrupt can go one of three ways. The block can resume directly. It can wait for an oscillator quality check. Or, with fast wake enabled, it can resume at once on the self clock and stay there until software releases the fast-wake bit. The oscillator, the PLL and the quality-check timer are outside the block and are seen only as handshake signals.

Top module: `stopclk_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the block is in run mode: source code 0 (oscillator), every clock enable high, PLL select 0, self-clock flag 0, no stop request, no check pulses.
- R2: A stop request taken in run mode shuts the tree down one step per cycle. If the PLL select is 1, the first step switches the source to 0 and clears the select. The PLL enable then falls, then the core enable, then all system enables together with the low-power request rising. If the select is 0, the switching step is skipped.
- R3: In full stop the oscillator, the real-time-interrupt clock and the watchdog clock are off. In pseudo stop the oscillator stays on, and each of those two clocks follows its own run enable.
- R4: The low-power request is high only in the stop state, and only when no PLL is being held for a running quality check. It is never high while the core or system clocks are on.
- R5: A pseudo stop taken from self-clock mode keeps the PLL on and keeps the self-clock status high, so the quality check keeps running. If the check passes while stopped, the PLL turns off, the low-power request rises and the flag sets. A wake before that resumes self-clock mode with no new check start.
- R6: A full stop taken from self-clock mode pulses the check abort in its first sequence cycle. The PLL is off in the stop state.
- R7: A wake interrupt in full stop without fast wake turns on the oscillator and pulses the check start. The core and system clocks stay off until the check passes, and the block then runs on the oscillator.
- R8: A wake interrupt in full stop with both fast wake and self-clock enable set resumes at once on the self clock (source code 2). The oscillator stays off, no check starts and the flag does not set. Fast wake with self-clock enable clear behaves as in R7.
- R9: In fast-wake self-clock mode, clearing the fast-wake bit turns on the oscillator and pulses the check start. A passing check then moves the tree to the oscillator and sets the flag.
- R10: The PLL select reads 0 after every stop exit. A software write to the select takes effect only in run mode, where a value of 1 selects source code 1 (PLL).
- R11: Oscillator loss in run mode with self-clock enable set enters self-clock mode: source code 2, check start pulse, flag set. With the enable clear, oscillator loss has no effect.
- R12: The self-clock flag is sticky and is cleared by a write-one pulse. A set in the same cycle wins over the clear. The interrupt output follows the flag.
- R13: A wake interrupt that arrives while the shutdown sequence is still running has no effect. The sequence still reaches the stop state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | Processor request to enter stop |
| wake_irq | input | 1 | Wake-up interrupt |
| cfg_pseudo_stop | input | 1 | 1 selects pseudo stop, 0 selects full stop |
| cfg_rti_run | input | 1 | Keep real-time-interrupt clock in pseudo stop |
| cfg_wdog_run | input | 1 | Keep watchdog clock in pseudo stop |
| cfg_scm_en | input | 1 | Self-clock mode enable |
| cfg_fast_wake | input | 1 | Fast-wake enable; clearing it releases fast-wake self-clock mode |
| pll_sel_wr | input | 1 | Software write strobe for the PLL select |
| pll_sel_wdata | input | 1 | Value written to the PLL select |
| osc_lost | input | 1 | Oscillator loss detected by the clock monitor |
| cqc_pass | input | 1 | Clock-quality check passed |
| scm_flag_clr | input | 1 | Write-one clear of the self-clock flag |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |
| core_clk_en | output | 1 | Core clock enable |
| sys_clk_en | output | N_SYS | System clock enables |
| rti_clk_en | output | 1 | Real-time-interrupt clock enable |
| wdog_clk_en | output | 1 | Watchdog clock enable |
| clk_src | output | 2 | Clock source: 0 oscillator, 1 PLL, 2 self clock |
| pll_sel | output | 1 | PLL select readback |
| scm_active | output | 1 | Self-clock mode status |
| scm_flag | output | 1 | Sticky self-clock flag |
| scm_irq | output | 1 | Interrupt, high while the flag is set |
| cqc_start | output | 1 | One-cycle pulse starting a full quality check |
| cqc_abort | output | 1 | One-cycle pulse aborting the running check |
| lp_req | output | 1 | Low-power request to other units |

## Verification
The bench steps through every shutdown step and checks the outputs in each one. A design that merged steps or swapped the PLL and core order would show the wrong enable pattern in some cycle. The bench covers pseudo stop taken from self-clock mode twice: once with the check passing during stop and once with a wake first. A design that dropped the PLL or restarted the check would show a wrong PLL enable, low-power request or start pulse. Fast wake is tried both with and without self-clock enable, and the flag is watched so that a design setting it on a fast wake, or letting a clear beat a set, shows a mismatch. The bench also holds a wake during the shutdown sequence and writes the PLL select in self-clock mode, both of which must leave no trace.

// File: rtl/stopclk_pkg.sv
package stopclk_pkg;

    typedef enum logic [2:0] {
        ST_RUN     = 3'd0,
        ST_SCM     = 3'd1,
        ST_FWK     = 3'd2,
        ST_DESEL   = 3'd3,
        ST_PLLOFF  = 3'd4,
        ST_COREOFF = 3'd5,
        ST_STOP    = 3'd6,
        ST_WCHK    = 3'd7
    } seq_state_e;

    typedef enum logic [1:0] {
        SRC_OSC  = 2'd0,
        SRC_PLL  = 2'd1,
        SRC_SELF = 2'd2
    } clk_src_e;

    typedef struct packed {
        seq_state_e state;
        logic       pll_sel;
        logic       pseudo;
        logic       from_scm;
        logic       keep_pll;
        logic       cqc_start;
        logic       cqc_abort;
    } seq_regs_t;

endpackage

// File: rtl/stopclk_fsm.sv
module stopclk_fsm
    import stopclk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      stop_req,
    input  logic      wake_irq,
    input  logic      osc_lost,
    input  logic      cqc_pass,
    input  logic      cfg_pseudo_stop,
    input  logic      cfg_scm_en,
    input  logic      cfg_fast_wake,
    input  logic      pll_sel_wr,
    input  logic      pll_sel_wdata,
    output seq_regs_t regs_q,
    output logic      flag_set
);

    seq_regs_t regs_d;
    logic      keep_after;

    always_comb begin
        regs_d           = regs_q;
        regs_d.cqc_start = 1'b0;
        regs_d.cqc_abort = 1'b0;
        flag_set         = 1'b0;
        keep_after       = regs_q.keep_pll && !cqc_pass;

        unique case (regs_q.state)
            ST_RUN: begin
                if (stop_req) begin
                    regs_d.pseudo   = cfg_pseudo_stop;
                    regs_d.from_scm = 1'b0;
                    regs_d.keep_pll = 1'b0;
                    if (regs_q.pll_sel) begin
                        regs_d.state   = ST_DESEL;
                        regs_d.pll_sel = 1'b0;
                    end else begin
                        regs_d.state = ST_PLLOFF;
                    end
                end else if (osc_lost && cfg_scm_en) begin
                    regs_d.state     = ST_SCM;
                    regs_d.pll_sel   = 1'b0;
                    regs_d.cqc_start = 1'b1;
                    flag_set         = 1'b1;
                end else if (pll_sel_wr) begin
                    regs_d.pll_sel = pll_sel_wdata;
                end
            end
            ST_DESEL:   regs_d.state = ST_PLLOFF;
            ST_PLLOFF:  regs_d.state = ST_COREOFF;
            ST_COREOFF: regs_d.state = ST_STOP;
            ST_STOP: begin
                if (regs_q.keep_pll && cqc_pass) begin
                    regs_d.keep_pll = 1'b0;
                    flag_set        = 1'b1;
                end
                if (wake_irq) begin
                    regs_d.keep_pll = 1'b0;
                    regs_d.from_scm = 1'b0;
                    if (regs_q.pseudo) begin
                        regs_d.state = keep_after ? ST_SCM : ST_RUN;
                    end else if (cfg_fast_wake && cfg_scm_en) begin
                        regs_d.state = ST_FWK;
                    end else begin
                        regs_d.state     = ST_WCHK;
                        regs_d.cqc_start = 1'b1;
                    end
                end
            end
            ST_WCHK: begin
                if (cqc_pass) regs_d.state = ST_RUN;
            end
            ST_FWK: begin
                if (!cfg_fast_wake) begin
                    regs_d.state     = ST_SCM;
                    regs_d.cqc_start = 1'b1;
                end
            end
            ST_SCM: begin
                if (stop_req) begin
                    regs_d.state     = ST_COREOFF;
                    regs_d.from_scm  = 1'b1;
                    regs_d.pseudo    = cfg_pseudo_stop;
                    regs_d.keep_pll  = cfg_pseudo_stop;
                    regs_d.cqc_abort = !cfg_pseudo_stop;
                end else if (cqc_pass) begin
                    regs_d.state = ST_RUN;
                    flag_set     = 1'b1;
                end
            end
            default: regs_d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{state: ST_RUN, default: 1'b0};
        end else begin
            regs_q <= regs_d;
        end
    end

endmodule

// File: rtl/stopclk_decode.sv
module stopclk_decode
    import stopclk_pkg::*;
#(
    parameter int N_SYS = 4
) (
    input  seq_regs_t        regs_q,
    input  logic             cfg_rti_run,
    input  logic             cfg_wdog_run,
    output logic             osc_en,
    output logic             pll_en,
    output logic             core_clk_en,
    output logic [N_SYS-1:0] sys_clk_en,
    output logic             rti_clk_en,
    output logic             wdog_clk_en,
    output logic [1:0]       clk_src,
    output logic             scm_active,
    output logic             lp_req
);

    logic     sys_on;
    clk_src_e src;

    always_comb begin
        osc_en      = 1'b1;
        pll_en      = 1'b1;
        core_clk_en = 1'b1;
        sys_on      = 1'b1;
        src         = SRC_OSC;
        scm_active  = 1'b0;
        lp_req      = 1'b0;
        rti_clk_en  = 1'b1;
        wdog_clk_en = 1'b1;

        unique case (regs_q.state)
            ST_RUN: src = regs_q.pll_sel ? SRC_PLL : SRC_OSC;
            ST_SCM: begin
                src        = SRC_SELF;
                scm_active = 1'b1;
            end
            ST_FWK: begin
                osc_en     = 1'b0;
                src        = SRC_SELF;
                scm_active = 1'b1;
            end
            ST_DESEL:  src = SRC_OSC;
            ST_PLLOFF: pll_en = 1'b0;
            ST_COREOFF: begin
                pll_en      = regs_q.from_scm;
                core_clk_en = 1'b0;
                src         = regs_q.from_scm ? SRC_SELF : SRC_OSC;
                scm_active  = regs_q.from_scm;
            end
            ST_STOP: begin
                osc_en      = regs_q.pseudo;
                pll_en      = regs_q.keep_pll;
                core_clk_en = 1'b0;
                sys_on      = 1'b0;
                src         = regs_q.keep_pll ? SRC_SELF : SRC_OSC;
                scm_active  = regs_q.keep_pll;
                lp_req      = !regs_q.keep_pll;
                rti_clk_en  = regs_q.pseudo && cfg_rti_run;
                wdog_clk_en = regs_q.pseudo && cfg_wdog_run;
            end
            ST_WCHK: begin
                pll_en      = 1'b0;
                core_clk_en = 1'b0;
                sys_on      = 1'b0;
                rti_clk_en  = 1'b0;
                wdog_clk_en = 1'b0;
            end
            default: src = SRC_OSC;
        endcase
    end

    assign clk_src = src;

    for (genvar g = 0; g < N_SYS; g++) begin : g_sys
        assign sys_clk_en[g] = sys_on;
    end

endmodule

// File: rtl/stopclk_flag.sv
module stopclk_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag,
    output logic irq
);

    logic flag_d;
    logic flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr) flag_d = 1'b0;
        if (set) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag = flag_q;
    assign irq  = flag_q;

endmodule

// File: rtl/stopclk_seq.sv
module stopclk_seq
    import stopclk_pkg::*;
#(
    parameter int N_SYS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_req,
    input  logic             wake_irq,
    input  logic             cfg_pseudo_stop,
    input  logic             cfg_rti_run,
    input  logic             cfg_wdog_run,
    input  logic             cfg_scm_en,
    input  logic             cfg_fast_wake,
    input  logic             pll_sel_wr,
    input  logic             pll_sel_wdata,
    input  logic             osc_lost,
    input  logic             cqc_pass,
    input  logic             scm_flag_clr,
    output logic             osc_en,
    output logic             pll_en,
    output logic             core_clk_en,
    output logic [N_SYS-1:0] sys_clk_en,
    output logic             rti_clk_en,
    output logic             wdog_clk_en,
    output logic [1:0]       clk_src,
    output logic             pll_sel,
    output logic             scm_active,
    output logic             scm_flag,
    output logic             scm_irq,
    output logic             cqc_start,
    output logic             cqc_abort,
    output logic             lp_req
);

    seq_regs_t regs_q;
    logic      flag_set;

    stopclk_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .stop_req        (stop_req),
        .wake_irq        (wake_irq),
        .osc_lost        (osc_lost),
        .cqc_pass        (cqc_pass),
        .cfg_pseudo_stop (cfg_pseudo_stop),
        .cfg_scm_en      (cfg_scm_en),
        .cfg_fast_wake   (cfg_fast_wake),
        .pll_sel_wr      (pll_sel_wr),
        .pll_sel_wdata   (pll_sel_wdata),
        .regs_q          (regs_q),
        .flag_set        (flag_set)
    );

    stopclk_decode #(.N_SYS(N_SYS)) u_dec (
        .regs_q       (regs_q),
        .cfg_rti_run  (cfg_rti_run),
        .cfg_wdog_run (cfg_wdog_run),
        .osc_en       (osc_en),
        .pll_en       (pll_en),
        .core_clk_en  (core_clk_en),
        .sys_clk_en   (sys_clk_en),
        .rti_clk_en   (rti_clk_en),
        .wdog_clk_en  (wdog_clk_en),
        .clk_src      (clk_src),
        .scm_active   (scm_active),
        .lp_req       (lp_req)
    );

    stopclk_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_set),
        .clr   (scm_flag_clr),
        .flag  (scm_flag),
        .irq   (scm_irq)
    );

    assign pll_sel   = regs_q.pll_sel;
    assign cqc_start = regs_q.cqc_start;
    assign cqc_abort = regs_q.cqc_abort;

endmodule

// File: rtl/stopclk_sva.sv
module stopclk_sva #(
    parameter int N_SYS = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scm_flag_clr,
    input logic             osc_en,
    input logic             pll_en,
    input logic             core_clk_en,
    input logic [N_SYS-1:0] sys_clk_en,
    input logic             rti_clk_en,
    input logic             wdog_clk_en,
    input logic [1:0]       clk_src,
    input logic             pll_sel,
    input logic             scm_flag,
    input logic             cqc_start,
    input logic             cqc_abort,
    input logic             lp_req
);

    assert_core_needs_sys_R2: assert property (@(posedge clk) disable iff (!rst_n)
        core_clk_en |-> (&sys_clk_en));

    assert_pll_off_before_core_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(core_clk_en) && clk_src == 2'd0) |-> !pll_en);

    assert_lp_only_when_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lp_req |-> (!core_clk_en && !(|sys_clk_en)));

    assert_full_stop_timers_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_req && !osc_en) |-> (!rti_clk_en && !wdog_clk_en));

    assert_fast_wake_no_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(core_clk_en) && !osc_en) |-> !$rose(scm_flag));

    assert_flag_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scm_flag) |-> $past(scm_flag_clr));

    assert_pll_src_needs_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_src == 2'd1) |-> pll_sel);

    assert_exit_sel_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|sys_clk_en) |-> !pll_sel);

    assert_start_needs_osc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cqc_start |-> (osc_en && !cqc_abort));

endmodule

bind stopclk_seq stopclk_sva #(.N_SYS(N_SYS)) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .scm_flag_clr (scm_flag_clr),
    .osc_en       (osc_en),
    .pll_en       (pll_en),
    .core_clk_en  (core_clk_en),
    .sys_clk_en   (sys_clk_en),
    .rti_clk_en   (rti_clk_en),
    .wdog_clk_en  (wdog_clk_en),
    .clk_src      (clk_src),
    .pll_sel      (pll_sel),
    .scm_flag     (scm_flag),
    .cqc_start    (cqc_start),
    .cqc_abort    (cqc_abort),
    .lp_req       (lp_req)
);

// File: tb/sim_stopclk_seq.sv
module sim_stopclk_seq;

    localparam int N_SYS = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_req = 1'b0, wake_irq = 1'b0, cfg_pseudo_stop = 1'b0;
    logic cfg_rti_run = 1'b0, cfg_wdog_run = 1'b0, cfg_scm_en = 1'b0;
    logic cfg_fast_wake = 1'b0, pll_sel_wr = 1'b0, pll_sel_wdata = 1'b0;
    logic osc_lost = 1'b0, cqc_pass = 1'b0, scm_flag_clr = 1'b0;

    logic             osc_en, pll_en, core_clk_en, rti_clk_en, wdog_clk_en;
    logic [N_SYS-1:0] sys_clk_en;
    logic [1:0]       clk_src;
    logic             pll_sel, scm_active, scm_flag, scm_irq;
    logic             cqc_start, cqc_abort, lp_req;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    int          q_cyc[$];
    logic [15:0] q_exp[$];
    string       q_tag[$];

    always #10 clk = ~clk;

    stopclk_seq #(.N_SYS(N_SYS)) u0 (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .wake_irq(wake_irq),
        .cfg_pseudo_stop(cfg_pseudo_stop), .cfg_rti_run(cfg_rti_run),
        .cfg_wdog_run(cfg_wdog_run), .cfg_scm_en(cfg_scm_en),
        .cfg_fast_wake(cfg_fast_wake), .pll_sel_wr(pll_sel_wr),
        .pll_sel_wdata(pll_sel_wdata), .osc_lost(osc_lost), .cqc_pass(cqc_pass),
        .scm_flag_clr(scm_flag_clr), .osc_en(osc_en), .pll_en(pll_en),
        .core_clk_en(core_clk_en), .sys_clk_en(sys_clk_en),
        .rti_clk_en(rti_clk_en), .wdog_clk_en(wdog_clk_en), .clk_src(clk_src),
        .pll_sel(pll_sel), .scm_active(scm_active), .scm_flag(scm_flag),
        .scm_irq(scm_irq), .cqc_start(cqc_start), .cqc_abort(cqc_abort),
        .lp_req(lp_req)
    );

    // Order: osc pll core sys_all sys_any src[1:0] psel scm flag irq lp rti wdog start abort
    function automatic logic [15:0] mk(logic o, logic p, logic c, logic s,
                                       logic [1:0] src, logic ps, logic sa,
                                       logic f, logic lp, logic r, logic w,
                                       logic cs, logic ca);
        return {o, p, c, s, s, src, ps, sa, f, f, lp, r, w, cs, ca};
    endfunction

    function automatic logic [15:0] observe();
        return {osc_en, pll_en, core_clk_en, &sys_clk_en, |sys_clk_en, clk_src,
                pll_sel, scm_active, scm_flag, scm_irq, lp_req, rti_clk_en,
                wdog_clk_en, cqc_start, cqc_abort};
    endfunction

    task automatic compare(input logic [15:0] exp, input string tag);
        logic [15:0] act;
        act = observe();
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %b expected %b", tag, cyc, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pops expected items whose cycle has been reached
    always @(negedge clk) begin
        while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
            compare(q_exp[0], q_tag[0]);
            void'(q_cyc.pop_front());
            void'(q_exp.pop_front());
            void'(q_tag.pop_front());
        end
    end

    // Driver: expectation for the state after the next rising edge
    task automatic step(input logic [15:0] exp, input string tag);
        q_cyc.push_back(cyc + 1);
        q_exp.push_back(exp);
        q_tag.push_back(tag);
        @(posedge clk);
        #1;
    endtask

    function automatic logic [15:0] run_st(logic ps, logic f);
        return mk(1, 1, 1, 1, ps ? 2'd1 : 2'd0, ps, 0, f, 0, 1, 1, 0, 0);
    endfunction

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        cfg_rti_run  = 1'b1;
        cfg_wdog_run = 1'b1;
        repeat (2) @(posedge clk);
        #5;
        compare(run_st(0, 0), "R1 in reset");
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        step(run_st(0, 0), "R1 after reset");

        // R10: select PLL in run mode
        pll_sel_wr = 1; pll_sel_wdata = 1;
        step(run_st(1, 0), "R10 select write");
        pll_sel_wr = 0;

        // R2: full stop with PLL selected, ordered shutdown
        stop_req = 1; cfg_pseudo_stop = 0;
        step(mk(1, 1, 1, 1, 0, 0, 0, 0, 0, 1, 1, 0, 0), "R2 deselect");
        stop_req = 0;
        step(mk(1, 0, 1, 1, 0, 0, 0, 0, 0, 1, 1, 0, 0), "R2 pll off");
        wake_irq = 1;
        step(mk(1, 0, 0, 1, 0, 0, 0, 0, 0, 1, 1, 0, 0), "R13 wake during core off");
        wake_irq = 0;
        step(mk(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0), "R3 full stop");
        step(mk(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0), "R4 stop held");
        wake_irq = 1;
        step(mk(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0), "R7 wake check start");
        wake_irq = 0;
        step(mk(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0), "R7 clocks held");
        cqc_pass = 1;
        step(run_st(0, 0), "R10 select clear after exit");
        cqc_pass = 0;

        // R3: pseudo stop, select already clear
        cfg_pseudo_stop = 1; cfg_wdog_run = 0;
        stop_req = 1;
        step(mk(1, 0, 1, 1, 0, 0, 0, 0, 0, 1, 1, 0, 0), "R2 skip deselect");
        stop_req = 0;
        step(mk(1, 0, 0, 1, 0, 0, 0, 0, 0, 1, 1, 0, 0), "R2 core off");
        step(mk(1, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0), "R3 pseudo stop");
        wake_irq = 1;
        step(run_st(0, 0), "R3 pseudo wake direct");
        wake_irq = 0;

        // R11: oscillator loss
        osc_lost = 1;
        step(run_st(0, 0), "R11 loss ignored");
        cfg_scm_en = 1;
        step(mk(1, 1, 1, 1, 2, 0, 1, 1, 0, 1, 1, 1, 0), "R11 enter self clock");
        osc_lost = 0;
        pll_sel_wr = 1; pll_sel_wdata = 1;
        step(mk(1, 1, 1, 1, 2, 0, 1, 1, 0, 1, 1, 0, 0), "R10 write ignored");
        pll_sel_wr = 0;
        scm_flag_clr = 1;
        step(mk(1, 1, 1, 1, 2, 0, 1, 0, 0, 1, 1, 0, 0), "R12 clear");
        scm_flag_clr = 0;

        // R6/R8/R9: full stop from self clock, fast wake
        cfg_pseudo_stop = 0; stop_req = 1;
        step(mk(1, 1, 0, 1, 2, 0, 1, 0, 0, 1, 1, 0, 1), "R6 abort");
        stop_req = 0;
        step(mk(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0), "R6 stop pll off");
        cfg_fast_wake = 1; wake_irq = 1;
        step(mk(0, 1, 1, 1, 2, 0, 1, 0, 0, 1, 1, 0, 0), "R8 fast wake");
        wake_irq = 0;
        step(mk(0, 1, 1, 1, 2, 0, 1, 0, 0, 1, 1, 0, 0), "R9 held on self clock");
        cfg_fast_wake = 0;
        step(mk(1, 1, 1, 1, 2, 0, 1, 0, 0, 1, 1, 1, 0), "R9 release start");
        step(mk(1, 1, 1, 1, 2, 0, 1, 0, 0, 1, 1, 0, 0), "R9 checking");
        cqc_pass = 1; scm_flag_clr = 1;
        step(run_st(0, 1), "R12 set wins");
        cqc_pass = 0; scm_flag_clr = 0;
        step(run_st(0, 1), "R12 sticky");

        // R5: pseudo stop from self clock, wake before pass
        scm_flag_clr = 1;
        step(run_st(0, 0), "R12 clear in run");
        scm_flag_clr = 0;
        osc_lost = 1;
        step(mk(1, 1, 1, 1, 2, 0, 1, 1, 0, 1, 1, 1, 0), "R11 enter again");
        osc_lost = 0;
        cfg_pseudo_stop = 1; stop_req = 1;
        step(mk(1, 1, 0, 1, 2, 0, 1, 1, 0, 1, 1, 0, 0), "R5 core off keep pll");
        stop_req = 0;
        step(mk(1, 1, 0, 0, 2, 0, 1, 1, 0, 1, 0, 0, 0), "R5 stop keep pll");
        wake_irq = 1;
        step(mk(1, 1, 1, 1, 2, 0, 1, 1, 0, 1, 1, 0, 0), "R5 wake to self clock");
        wake_irq = 0;
        cqc_pass = 1;
        step(run_st(0, 1), "R5 pass to run");
        cqc_pass = 0;

        // R5: pass during pseudo stop
        osc_lost = 1;
        step(mk(1, 1, 1, 1, 2, 0, 1, 1, 0, 1, 1, 1, 0), "R11 enter third");
        osc_lost = 0;
        stop_req = 1; scm_flag_clr = 1;
        step(mk(1, 1, 0, 1, 2, 0, 1, 0, 0, 1, 1, 0, 0), "R5 core off");
        stop_req = 0; scm_flag_clr = 0;
        step(mk(1, 1, 0, 0, 2, 0, 1, 0, 0, 1, 0, 0, 0), "R5 stop checking");
        cqc_pass = 1;
        step(mk(1, 0, 0, 0, 0, 0, 0, 1, 1, 1, 0, 0, 0), "R5 pass in stop");
        cqc_pass = 0;
        wake_irq = 1;
        step(run_st(0, 1), "R5 wake after pass");
        wake_irq = 0;

        // R8: fast wake needs self-clock enable
        cfg_scm_en = 0; cfg_fast_wake = 1; cfg_pseudo_stop = 0;
        stop_req = 1;
        step(mk(1, 0, 1, 1, 0, 0, 0, 1, 0, 1, 1, 0, 0), "R2 pll off");
        stop_req = 0;
        step(mk(1, 0, 0, 1, 0, 0, 0, 1, 0, 1, 1, 0, 0), "R2 core off");
        step(mk(0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0), "R3 full stop");
        wake_irq = 1;
        step(mk(1, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 1, 0), "R8 no fast wake");
        wake_irq = 0;
        cqc_pass = 1;
        step(run_st(0, 1), "R7 pass to run");
        cqc_pass = 0;

        @(negedge clk);
        #2;
        done = 1'b1;
        finish_run();
    end

endmodule